// File: doc/BRIEF.md
# Transfer Descriptor Token Updater

This block holds the live execution state of a single USB host transfer descriptor and moves it forward as bus transactions finish. A descriptor is loaded in one cycle: its remaining byte count, active flag, interrupt-on-complete flag, data toggle, buffer page index, buffer offset and two link pointers (primary next and alternate next). While the descriptor is active the block presents a transaction request carrying the length of the next transaction.

The transaction engine returns one result per transaction over a valid/ready handshake: the bytes actually moved, whether the transaction succeeded, a short-packet flag and the packet direction. On each accepted successful result the block lowers the byte count, advances the buffer offset and page index, and flips the data toggle when toggle control comes from the descriptor. When the descriptor retires, it clears the active flag, pulses a completion strobe, latches the chosen link pointer, reports whether that pointer ends the queue and raises an interrupt request if one was enabled.

Top module: `td_token_updater`

## Requirements
- R1: Each accepted result with `res_ok`=1 lowers `bytes_left` by the bytes moved (clamped to the bytes left); a result with `res_ok`=0 leaves `bytes_left`, `offset`, `page` and `toggle` unchanged.
- R2: A load with a byte count above 20480 (0x5000, five 4 KB pages) sets `err_len` and leaves the descriptor inactive; a load of 0x5000 or less clears `err_len`.
- R3: A descriptor loaded active with a byte count of 0 raises `req_valid` with `req_zero`=1 and `req_len`=0; the first successful result then retires it and selects the primary next pointer.
- R4: `req_len` equals the smaller of `bytes_left` and `max_pkt`, so a count that is not a multiple of `max_pkt` ends with a shorter final request.
- R5: `offset` holds the low 12 bits of the running buffer position; when a successful transaction carries it past a 4 KB boundary with bytes still remaining, `page` rises by one.
- R6: `page` never exceeds 4; a boundary crossing while `page`=4 with bytes remaining sets `err_page` and keeps `page` at 4.
- R7: With `tog_ctl`=1 the toggle inverts after every successful transaction; with `tog_ctl`=0 it stays as loaded.
- R8: When a successful transaction brings `bytes_left` to 0, the descriptor retires: `active` clears, `done` is high for exactly one cycle and `next_ptr` takes the primary next pointer.
- R9: A successful IN result (`res_in`=1) with `res_short`=1 and bytes still remaining retires the descriptor at once and selects the alternate pointer; a short OUT result does not retire it.
- R10: Link pointers carry address bits 31:5 and a terminate flag in bit 0 (1 = invalid); `queue_empty` equals bit 0 of the selected pointer after retirement and is 0 after a load.
- R11: If the loaded interrupt-on-complete flag is 1, retirement sets `irq_pending`, which stays set until the next load; with the flag at 0 it stays clear.
- R12: While `active` is 0, `res_ready` is 0 and results change no state and produce no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load a new descriptor this cycle |
| ld_bytes | input | 16 | Total byte count to load |
| ld_active | input | 1 | Active flag of the loaded descriptor |
| ld_ioc | input | 1 | Interrupt-on-complete flag |
| ld_toggle | input | 1 | Initial data toggle |
| ld_page | input | 3 | Initial buffer page index |
| ld_offset | input | 12 | Initial offset within the page |
| ld_next | input | 32 | Primary next link pointer |
| ld_alt | input | 32 | Alternate next link pointer |
| tog_ctl | input | 1 | 1: toggle is driven by the descriptor |
| max_pkt | input | 11 | Maximum packet length of the endpoint |
| res_valid | input | 1 | Transaction result valid |
| res_bytes | input | 16 | Bytes moved by the transaction |
| res_ok | input | 1 | Transaction succeeded |
| res_short | input | 1 | Transaction ended in a short packet |
| res_in | input | 1 | Transaction direction was IN |
| res_ready | output | 1 | Result accepted this cycle |
| req_valid | output | 1 | A transaction is requested |
| req_len | output | 16 | Length of the requested transaction |
| req_zero | output | 1 | Requested transaction is zero-length |
| active | output | 1 | Descriptor is active |
| bytes_left | output | 16 | Remaining byte count |
| page | output | 3 | Current buffer page index |
| offset | output | 12 | Current offset within the page |
| toggle | output | 1 | Current data toggle |
| done | output | 1 | One-cycle retirement strobe |
| next_ptr | output | 32 | Selected link pointer |
| queue_empty | output | 1 | Selected pointer has its terminate flag set |
| irq_pending | output | 1 | Interrupt request after retirement |
| err_len | output | 1 | Loaded byte count was over the limit |
| err_page | output | 1 | Page index tried to pass its last value |

## Verification
The assertions take for granted that `max_pkt` is below 4096, so one transaction never crosses more than one 4 KB boundary, and that `rst` is held for at least one clock edge before any load. The stimulus keeps `max_pkt` at 512 and reports bytes moved no larger than the request, apart from one deliberate overshoot that checks the clamp. Loads never coincide with a result, so every accepted result acts on a settled descriptor.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
    localparam int CNT_W     = 16;
    localparam int OFS_W     = 12;
    localparam int PAGE_W    = 3;
    localparam int PTR_W     = 32;
    localparam int LEN_W     = 11;
    localparam int NUM_PAGES = 5;

    localparam logic [PAGE_W-1:0] LAST_PAGE  = PAGE_W'(NUM_PAGES - 1);
    localparam logic [CNT_W-1:0]  BYTE_LIMIT = CNT_W'(NUM_PAGES) << OFS_W;

    typedef struct packed {
        logic              active;
        logic              zlen;
        logic              ioc;
        logic              toggle;
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  offset;
        logic [CNT_W-1:0]  bytes;
    } td_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] bytes;
        logic             ok;
        logic             short_pkt;
        logic             dir_in;
    } txn_res_t;

    function automatic logic [CNT_W-1:0] min_cnt(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/tdu_xfer_calc.sv
module tdu_xfer_calc import tdu_pkg::*; (
    input  td_state_t cur,
    input  txn_res_t  res,
    input  logic      tog_ctl,
    output td_state_t nxt,
    output logic      retire,
    output logic      use_alt,
    output logic      page_err
);
    logic [CNT_W-1:0] moved;
    logic [CNT_W-1:0] remain;
    logic [OFS_W:0]   ofs_sum;
    logic             carry;

    always_comb begin
        moved    = min_cnt(res.bytes, cur.bytes);
        remain   = cur.bytes - moved;
        ofs_sum  = {1'b0, cur.offset} + moved[OFS_W:0];
        carry    = ofs_sum[OFS_W];
        nxt      = cur;
        retire   = 1'b0;
        use_alt  = 1'b0;
        page_err = 1'b0;
        if (res.ok) begin
            nxt.bytes  = remain;
            nxt.offset = ofs_sum[OFS_W-1:0];
            if (carry && remain != '0) begin
                if (cur.page >= LAST_PAGE) page_err = 1'b1;
                else                       nxt.page = cur.page + 1'b1;
            end
            if (tog_ctl) nxt.toggle = ~cur.toggle;
            if (cur.zlen || remain == '0) begin
                retire = 1'b1;
            end else if (res.short_pkt && res.dir_in) begin
                retire  = 1'b1;
                use_alt = 1'b1;
            end
            if (retire) nxt.active = 1'b0;
        end
    end

    // R9: the alternate link is only ever chosen as part of a retirement
    always_comb a_r9_alt_needs_retire: assert (!(use_alt && !retire));
    // R1: a result never makes the remaining count grow
    always_comb a_r1_no_growth: assert (nxt.bytes <= cur.bytes);
endmodule

// File: rtl/tdu_link_sel.sv
module tdu_link_sel import tdu_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             retire_en,
    input  logic             use_alt,
    input  logic [PTR_W-1:0] pri_ptr,
    input  logic [PTR_W-1:0] alt_ptr,
    output logic [PTR_W-1:0] sel_ptr,
    output logic             empty
);
    logic [PTR_W-1:0] pick;

    assign pick = use_alt ? alt_ptr : pri_ptr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sel_ptr <= '0;
            empty   <= 1'b0;
        end else if (retire_en) begin
            sel_ptr <= pick;
            empty   <= pick[0];
        end
    end

    // R10: the queue-empty flag follows the terminate flag of the chosen link
    a_r10_empty_tracks_term: assert property (@(posedge clk) disable iff (rst)
        (retire_en && !clear) |=> (empty == $past(use_alt ? alt_ptr[0] : pri_ptr[0])));
endmodule

// File: rtl/td_token_updater.sv
module td_token_updater import tdu_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [CNT_W-1:0]  ld_bytes,
    input  logic              ld_active,
    input  logic              ld_ioc,
    input  logic              ld_toggle,
    input  logic [PAGE_W-1:0] ld_page,
    input  logic [OFS_W-1:0]  ld_offset,
    input  logic [PTR_W-1:0]  ld_next,
    input  logic [PTR_W-1:0]  ld_alt,
    input  logic              tog_ctl,
    input  logic [LEN_W-1:0]  max_pkt,
    input  logic              res_valid,
    input  logic [CNT_W-1:0]  res_bytes,
    input  logic              res_ok,
    input  logic              res_short,
    input  logic              res_in,
    output logic              res_ready,
    output logic              req_valid,
    output logic [CNT_W-1:0]  req_len,
    output logic              req_zero,
    output logic              active,
    output logic [CNT_W-1:0]  bytes_left,
    output logic [PAGE_W-1:0] page,
    output logic [OFS_W-1:0]  offset,
    output logic              toggle,
    output logic              done,
    output logic [PTR_W-1:0]  next_ptr,
    output logic              queue_empty,
    output logic              irq_pending,
    output logic              err_len,
    output logic              err_page
);
    td_state_t        st_q, st_nx;
    txn_res_t         res;
    logic [PTR_W-1:0] pri_q, alt_q;
    logic             done_q, irq_q, err_len_q, err_page_q;
    logic             take, retire, use_alt, page_err;
    logic             over, page_bad;

    assign res      = '{bytes: res_bytes, ok: res_ok, short_pkt: res_short, dir_in: res_in};
    assign take     = res_valid && st_q.active && !ld_valid;
    assign over     = ld_bytes > BYTE_LIMIT;
    assign page_bad = ld_page > LAST_PAGE;

    tdu_xfer_calc u_calc (
        .cur      (st_q),
        .res      (res),
        .tog_ctl  (tog_ctl),
        .nxt      (st_nx),
        .retire   (retire),
        .use_alt  (use_alt),
        .page_err (page_err)
    );

    tdu_link_sel u_link (
        .clk       (clk),
        .rst       (rst),
        .clear     (ld_valid),
        .retire_en (take && retire),
        .use_alt   (use_alt),
        .pri_ptr   (pri_q),
        .alt_ptr   (alt_q),
        .sel_ptr   (next_ptr),
        .empty     (queue_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            pri_q      <= '0;
            alt_q      <= '0;
            done_q     <= 1'b0;
            irq_q      <= 1'b0;
            err_len_q  <= 1'b0;
            err_page_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ld_valid) begin
                pri_q         <= ld_next;
                alt_q         <= ld_alt;
                irq_q         <= 1'b0;
                err_len_q     <= over;
                err_page_q    <= page_bad;
                st_q.active   <= ld_active && !over && !page_bad;
                st_q.zlen     <= (ld_bytes == '0);
                st_q.ioc      <= ld_ioc;
                st_q.toggle   <= ld_toggle;
                st_q.page     <= page_bad ? LAST_PAGE : ld_page;
                st_q.offset   <= ld_offset;
                st_q.bytes    <= over ? '0 : ld_bytes;
            end else if (take) begin
                st_q <= st_nx;
                if (page_err) err_page_q <= 1'b1;
                if (retire) begin
                    done_q <= 1'b1;
                    if (st_q.ioc) irq_q <= 1'b1;
                end
            end
        end
    end

    assign res_ready   = st_q.active && !ld_valid;
    assign req_valid   = st_q.active;
    assign req_zero    = st_q.zlen;
    assign req_len     = st_q.zlen ? '0 : min_cnt(st_q.bytes, CNT_W'(max_pkt));
    assign active      = st_q.active;
    assign bytes_left  = st_q.bytes;
    assign page        = st_q.page;
    assign offset      = st_q.offset;
    assign toggle      = st_q.toggle;
    assign done        = done_q;
    assign irq_pending = irq_q;
    assign err_len     = err_len_q;
    assign err_page    = err_page_q;

    // R12: results offered to an inactive descriptor leave it untouched
    a_r12_ignore_idle: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !active && !ld_valid) |=> ($stable(bytes_left) && $stable(toggle) && !done));
    // R2: the stored count never exceeds the five-page limit
    a_r2_count_limit: assert property (@(posedge clk) disable iff (rst)
        bytes_left <= BYTE_LIMIT);
    // R6: page index stays within 0..4
    a_r6_page_range: assert property (@(posedge clk) disable iff (rst)
        page <= LAST_PAGE);
    // R8: the completion strobe only appears with the descriptor inactive and lasts one cycle
    a_r8_done_inactive: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && !$past(done)));
    // R11: an enabled interrupt is raised by retirement
    a_r11_irq_on_retire: assert property (@(posedge clk) disable iff (rst)
        (take && retire && st_q.ioc) |=> irq_pending);
endmodule

// File: tb/td_token_updater_test.sv
module td_token_updater_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_valid, ld_active, ld_ioc, ld_toggle;
    logic [15:0] ld_bytes;
    logic [2:0]  ld_page;
    logic [11:0] ld_offset;
    logic [31:0] ld_next, ld_alt;
    logic        tog_ctl;
    logic [10:0] max_pkt;
    logic        res_valid, res_ok, res_short, res_in;
    logic [15:0] res_bytes;
    logic        res_ready, req_valid, req_zero, active, toggle, done;
    logic [15:0] req_len, bytes_left;
    logic [2:0]  page;
    logic [11:0] offset;
    logic [31:0] next_ptr;
    logic        queue_empty, irq_pending, err_len, err_page;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    td_token_updater uut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_bytes(ld_bytes),
        .ld_active(ld_active), .ld_ioc(ld_ioc), .ld_toggle(ld_toggle),
        .ld_page(ld_page), .ld_offset(ld_offset), .ld_next(ld_next), .ld_alt(ld_alt),
        .tog_ctl(tog_ctl), .max_pkt(max_pkt), .res_valid(res_valid),
        .res_bytes(res_bytes), .res_ok(res_ok), .res_short(res_short), .res_in(res_in),
        .res_ready(res_ready), .req_valid(req_valid), .req_len(req_len),
        .req_zero(req_zero), .active(active), .bytes_left(bytes_left), .page(page),
        .offset(offset), .toggle(toggle), .done(done), .next_ptr(next_ptr),
        .queue_empty(queue_empty), .irq_pending(irq_pending), .err_len(err_len),
        .err_page(err_page)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] nbytes, input logic act, input logic ioc,
                        input logic tog, input logic [2:0] pg, input logic [11:0] ofs,
                        input logic [31:0] nxt, input logic [31:0] alt);
        @(negedge clk);
        ld_valid = 1'b1; ld_bytes = nbytes; ld_active = act; ld_ioc = ioc;
        ld_toggle = tog; ld_page = pg; ld_offset = ofs; ld_next = nxt; ld_alt = alt;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic result(input logic [15:0] nbytes, input logic ok,
                          input logic shrt, input logic dir_in);
        @(negedge clk);
        res_valid = 1'b1; res_bytes = nbytes; res_ok = ok; res_short = shrt; res_in = dir_in;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("reset active", active, 0);
        chk("reset done", done, 0);
        chk("reset irq", irq_pending, 0);
        chk("reset errors", {err_len, err_page, queue_empty}, 0);
        chk("R12 reset res_ready", res_ready, 0);
    endtask

    task automatic t_normal;
        tog_ctl = 1'b1;
        load(16'd1000, 1, 1, 0, 3'd0, 12'd0, 32'h1000_0020, 32'h2000_0041);
        chk("R4 first req_len", req_len, 512);
        chk("R4 req_valid", req_valid, 1);
        result(16'd512, 1, 0, 1);
        chk("R1 bytes after 512", bytes_left, 488);
        chk("R7 toggle flipped", toggle, 1);
        chk("R4 final shorter req_len", req_len, 488);
        result(16'd100, 0, 0, 1);
        chk("R1 failed result keeps count", bytes_left, 488);
        chk("R1 failed result keeps toggle", toggle, 1);
        result(16'd488, 1, 0, 1);
        chk("R8 done pulse", done, 1);
        chk("R8 active cleared", active, 0);
        chk("R8 primary next", next_ptr, 32'h1000_0020);
        chk("R10 valid link not empty", queue_empty, 0);
        chk("R11 irq raised", irq_pending, 1);
        chk("R7 toggle flipped back", toggle, 0);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
        chk("R11 irq held", irq_pending, 1);
    endtask

    task automatic t_idle;
        result(16'd64, 1, 0, 1);
        chk("R12 idle count", bytes_left, 0);
        chk("R12 idle toggle", toggle, 0);
        chk("R12 idle no done", done, 0);
        load(16'd200, 0, 0, 0, 3'd0, 12'd0, 32'h1, 32'h1);
        chk("R12 loaded inactive", active, 0);
        chk("R11 irq cleared by load", irq_pending, 0);
        result(16'd50, 1, 0, 1);
        chk("R12 inactive keeps count", bytes_left, 200);
        chk("R12 inactive no done", done, 0);
    endtask

    task automatic t_short;
        tog_ctl = 1'b0;
        load(16'd2000, 1, 0, 1, 3'd0, 12'd0, 32'h3000_0001, 32'h4000_0060);
        result(16'd100, 1, 1, 1);
        chk("R9 IN short retires", done, 1);
        chk("R9 alternate link", next_ptr, 32'h4000_0060);
        chk("R1 short count", bytes_left, 1900);
        chk("R10 alt valid", queue_empty, 0);
        chk("R11 no irq when disabled", irq_pending, 0);
        chk("R7 toggle held", toggle, 1);
        load(16'd2000, 1, 0, 0, 3'd0, 12'd0, 32'h3000_0001, 32'h4000_0060);
        result(16'd100, 1, 1, 0);
        chk("R9 OUT short stays active", active, 1);
        chk("R9 OUT short no done", done, 0);
        chk("R9 OUT short count", bytes_left, 1900);
    endtask

    task automatic t_terminate;
        load(16'd300, 1, 0, 0, 3'd0, 12'd0, 32'h3000_0001, 32'h4000_0060);
        chk("R10 empty cleared by load", queue_empty, 0);
        result(16'd400, 1, 0, 1);
        chk("R1 clamp to zero", bytes_left, 0);
        chk("R8 retire on zero", done, 1);
        chk("R10 terminate link", next_ptr, 32'h3000_0001);
        chk("R10 queue empty", queue_empty, 1);
    endtask

    task automatic t_zero_len;
        load(16'd0, 1, 1, 0, 3'd0, 12'd0, 32'h5000_0080, 32'h6000_0001);
        chk("R3 req_valid", req_valid, 1);
        chk("R3 req_zero", req_zero, 1);
        chk("R3 req_len", req_len, 0);
        result(16'd0, 1, 0, 0);
        chk("R3 retire", done, 1);
        chk("R3 primary link", next_ptr, 32'h5000_0080);
        chk("R3 irq", irq_pending, 1);
    endtask

    task automatic t_limit;
        load(16'h5001, 1, 0, 0, 3'd0, 12'd0, 32'h1, 32'h1);
        chk("R2 err_len set", err_len, 1);
        chk("R2 inactive", active, 0);
        load(16'h5000, 1, 0, 0, 3'd0, 12'd0, 32'h1, 32'h1);
        chk("R2 err_len clear", err_len, 0);
        chk("R2 limit accepted", active, 1);
        chk("R2 limit count", bytes_left, 16'h5000);
    endtask

    task automatic t_pages;
        load(16'h5000, 1, 0, 0, 3'd0, 12'hF00, 32'h1, 32'h1);
        result(16'd512, 1, 0, 0);
        chk("R5 page advance", page, 1);
        chk("R5 offset wraps", offset, 12'h100);
        chk("R6 no error", err_page, 0);
        load(16'd1000, 1, 0, 0, 3'd4, 12'hF00, 32'h1, 32'h1);
        result(16'd512, 1, 0, 0);
        chk("R6 error on overflow", err_page, 1);
        chk("R6 page held at 4", page, 4);
        chk("R5 offset after overflow", offset, 12'h100);
        load(16'd256, 1, 0, 0, 3'd2, 12'hF00, 32'h1, 32'h1);
        chk("R6 error cleared by load", err_page, 0);
        result(16'd256, 1, 0, 0);
        chk("R5 no advance at end", page, 2);
        chk("R5 offset at boundary", offset, 0);
        chk("R8 retire at boundary", done, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ld_valid = 0; ld_bytes = 0; ld_active = 0; ld_ioc = 0; ld_toggle = 0;
        ld_page = 0; ld_offset = 0; ld_next = 0; ld_alt = 0; tog_ctl = 0; max_pkt = 11'd512;
        res_valid = 0; res_bytes = 0; res_ok = 0; res_short = 0; res_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_normal;
        t_idle;
        t_short;
        t_terminate;
        t_zero_len;
        t_limit;
        t_pages;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule